// File: doc/BRIEF.md
# Bit-Skew Correcting Receive Buffer

This block holds the bytes that arrive from a network line receiver, and the processor can read them back at any bit alignment. Each incoming byte is written on a strobe to the next location of a small circular store. Bytes at even locations go to one memory and bytes at odd locations go to a second memory. Because of this split, the addressed byte and the byte after it are both available in a single access, whatever the parity of the address.

A read supplies an alias made of a byte address and a three-bit bit offset. The block fetches the byte pair in one cycle and joins it into a 16-bit word, first byte high. A barrel shifter then returns the eight bits that start the chosen number of bit positions below the top of the word. When the sender and the receiver slip by a bit now and then, software keeps in step by moving its read alias one offset up or down. The receiver is never re-synchronised. Line decoding is left to software.

Top module: `skew_rx_buffer`

## Requirements
- R1: After reset, `rdValid` is 0 and `rdData` is 0.
- R2: Each cycle with `wrStrobe` high stores `wrData` at the write pointer and then advances the pointer by one. The pointer wraps from 2^ADDR_W-1 to 0, so the write that follows a full pass overwrites byte 0.
- R3: A cycle with `clear` high returns the write pointer to 0. If `wrStrobe` is also high in that cycle, its byte is stored at address 0 and the next strobe writes address 1.
- R4: `rdValid` is high in exactly the cycle after each cycle with `rdEn` high, and low otherwise. `rdData` is valid while `rdValid` is high.
- R5: The read alias is `{byteAddr, bitOff}`, with `bitOff` in bits [2:0] and `byteAddr` in the bits above them. With `bitOff` 0, the read returns byte[byteAddr] unchanged.
- R6: With `bitOff` k, the read returns bits [15-k:8-k] of the word {byte[n], byte[n+1]}, where n is `byteAddr`. The word is MSB first, so byte[n] occupies bits 15..8.
- R7: R6 holds for odd byte addresses as well, where byte n comes from the odd memory and byte n+1 from the even memory.
- R8: A read at the last byte address, 2^ADDR_W-1, takes its second byte from address 0.
- R9: A read issued in the same cycle as a write to one of the two bytes it fetches returns that byte's previous content. A read issued one cycle later returns the new content.
- R10: While `rdEn` is low, `rdData` keeps the value of the last read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Return the write pointer to address 0 |
| wrStrobe | input | 1 | Store `wrData` at the write pointer |
| wrData | input | 8 | Received byte |
| rdEn | input | 1 | Start a read at `rdAlias` |
| rdAlias | input | ADDR_W+3 | {byte address, bit offset[2:0]} |
| rdData | output | 8 | Bit-aligned byte from the most recent read |
| rdValid | output | 1 | `rdData` was produced by a read in the previous cycle |

## Verification
The receive write and the processor read can happen in the same cycle, and they can touch the same memory word. The bench issues a write to the byte at the pointer alongside a read of that byte at offset 0. It also pairs a write with a read one address below, at a non-zero offset, so the newly written byte is the second byte of the pair. The scoreboard takes its expected value from its own model as it stood before the write, and each of these reads is followed by a repeat read that must show the new byte. A cycle where a clear and a write fall together is also provoked, and it is judged by reading addresses 0 and 1 back.

// File: rtl/skew_rx_pkg.sv
package skew_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = $clog2(BYTE_W);
  localparam int PAIR_W = 2 * BYTE_W;

  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic [1:0] wrBank;  // [0] even memory, [1] odd memory
    logic       rdFire;  // capture a byte pair this cycle
    logic       rdSwap;  // first byte of the pair lives in the odd memory
  } skewCtrl_t;
endpackage

// File: rtl/skew_rx_ctrl.sv
module skew_rx_ctrl
  import skew_rx_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clear,
  input  logic                    wrStrobe,
  input  logic                    rdEn,
  input  logic [ADDR_W+OFF_W-1:0] rdAlias,
  output skewCtrl_t               ctl,
  output logic [ADDR_W-2:0]       wrIdx,
  output logic [ADDR_W-2:0]       evenRdIdx,
  output logic [ADDR_W-2:0]       oddRdIdx,
  output logic [OFF_W-1:0]        rdOff
);
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] wrBase;
  logic [ADDR_W-1:0] rdByte;
  logic [ADDR_W-1:0] rdNext;

  // A clear in the same cycle as a strobe redirects that strobe to address 0.
  assign wrBase = clear ? '0 : wrPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
    end else if (wrStrobe) begin
      wrPtr <= wrBase + 1'b1;
    end else if (clear) begin
      wrPtr <= '0;
    end
  end

  assign rdByte = rdAlias[ADDR_W+OFF_W-1:OFF_W];
  assign rdNext = rdByte + 1'b1;   // wraps to 0 past the last byte

  always_comb begin
    ctl.wrBank = 2'b00;
    if (wrStrobe) begin
      ctl.wrBank = wrBase[0] ? 2'b10 : 2'b01;
    end
    ctl.rdFire = rdEn;
    ctl.rdSwap = rdByte[0];
  end

  assign wrIdx     = wrBase[ADDR_W-1:1];
  // The even word sits at (n+1)/2 and the odd word at n/2, for either parity of n.
  assign evenRdIdx = rdNext[ADDR_W-1:1];
  assign oddRdIdx  = rdByte[ADDR_W-1:1];
  assign rdOff     = rdAlias[OFF_W-1:0];
endmodule

// File: rtl/skew_rx_bank.sv
module skew_rx_bank
  import skew_rx_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [BYTE_W-1:0] rdQ
);
  localparam int DEPTH = 1 << IDX_W;

  logic [BYTE_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) begin
      store[wrIdx] <= wrData;
    end
  end

  // Read-first: a same-cycle write is seen only by later reads.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (rdEn) begin
      rdQ <= store[rdIdx];
    end
  end
endmodule

// File: rtl/skew_rx_dpath.sv
module skew_rx_dpath
  import skew_rx_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  skewCtrl_t         ctl,
  input  logic [ADDR_W-2:0] wrIdx,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-2:0] evenRdIdx,
  input  logic [ADDR_W-2:0] oddRdIdx,
  input  logic [OFF_W-1:0]  rdOff,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdValid
);
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0]  bankRdIdx [2];
  logic [BYTE_W-1:0] bankQ     [2];
  logic              swapQ;
  logic [OFF_W-1:0]  offQ;
  logic [PAIR_W-1:0] pairWord;
  logic [PAIR_W-1:0] shiftedWord;

  assign bankRdIdx[0] = evenRdIdx;
  assign bankRdIdx[1] = oddRdIdx;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    skew_rx_bank #(.IDX_W(IDX_W)) i_bank (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (ctl.wrBank[b]),
      .wrIdx  (wrIdx),
      .wrData (wrData),
      .rdEn   (ctl.rdFire),
      .rdIdx  (bankRdIdx[b]),
      .rdQ    (bankQ[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swapQ   <= 1'b0;
      offQ    <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= ctl.rdFire;
      if (ctl.rdFire) begin
        swapQ <= ctl.rdSwap;
        offQ  <= rdOff;
      end
    end
  end

  // First byte of the pair goes high, so bits enter MSB first.
  assign pairWord    = swapQ ? {bankQ[1], bankQ[0]} : {bankQ[0], bankQ[1]};
  assign shiftedWord = pairWord << offQ;
  assign rdData      = shiftedWord[PAIR_W-1:BYTE_W];
endmodule

// File: rtl/skew_rx_buffer.sv
module skew_rx_buffer
  import skew_rx_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    clear,
  input  logic                    wrStrobe,
  input  logic [7:0]              wrData,
  input  logic                    rdEn,
  input  logic [ADDR_W+2:0]       rdAlias,
  output logic [7:0]              rdData,
  output logic                    rdValid
);
  skewCtrl_t         ctl;
  logic [ADDR_W-2:0] wrIdx;
  logic [ADDR_W-2:0] evenRdIdx;
  logic [ADDR_W-2:0] oddRdIdx;
  logic [OFF_W-1:0]  rdOff;

  skew_rx_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clear     (clear),
    .wrStrobe  (wrStrobe),
    .rdEn      (rdEn),
    .rdAlias   (rdAlias),
    .ctl       (ctl),
    .wrIdx     (wrIdx),
    .evenRdIdx (evenRdIdx),
    .oddRdIdx  (oddRdIdx),
    .rdOff     (rdOff)
  );

  skew_rx_dpath #(.ADDR_W(ADDR_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wrIdx     (wrIdx),
    .wrData    (wrData),
    .evenRdIdx (evenRdIdx),
    .oddRdIdx  (oddRdIdx),
    .rdOff     (rdOff),
    .rdData    (rdData),
    .rdValid   (rdValid)
  );
endmodule

// File: rtl/skew_rx_checks.sv
module skew_rx_checks
  import skew_rx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       wrStrobe,
  input logic       rdEn,
  input logic [7:0] rdData,
  input logic       rdValid,
  input skewCtrl_t  ctl
);
  assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  assert_no_spurious_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  assert_one_bank_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl.wrBank));

  assert_write_needs_strobe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.wrBank != 2'b00) == wrStrobe);
endmodule

bind skew_rx_buffer skew_rx_checks i_checks (
  .clk      (clk),
  .rstN     (rstN),
  .wrStrobe (wrStrobe),
  .rdEn     (rdEn),
  .rdData   (rdData),
  .rdValid  (rdValid),
  .ctl      (ctl)
);

// File: tb/test_skew_rx_buffer.sv
`timescale 1ns/1ps
module test_skew_rx_buffer;
  localparam int ADDR_W = 6;
  localparam int NBYTES = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clear = 1'b0;
  logic              wrStrobe = 1'b0;
  logic [7:0]        wrData = '0;
  logic              rdEn = 1'b0;
  logic [ADDR_W+2:0] rdAlias = '0;
  logic [7:0]        rdData;
  logic              rdValid;

  always #4 clk = ~clk;   // 125 MHz

  skew_rx_buffer #(.ADDR_W(ADDR_W)) i_skew_rx_buffer (
    .clk(clk), .rstN(rstN), .clear(clear), .wrStrobe(wrStrobe), .wrData(wrData),
    .rdEn(rdEn), .rdAlias(rdAlias), .rdData(rdData), .rdValid(rdValid)
  );

  int          checks = 0;
  int          fails = 0;
  bit          finished = 0;
  logic [7:0]  model [NBYTES];
  int          wp = 0;
  logic [7:0]  expQ [$];
  string       reqQ [$];
  logic [7:0]  lastExp = '0;

  task automatic checkEq(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expectRead(input int n, input int k);
    logic [15:0] w;
    w = {model[n], model[(n + 1) % NBYTES]};
    w = w << k;
    return w[15:8];
  endfunction

  // One clock of stimulus; the expected read value is taken before the write lands.
  task automatic step(input bit doWr, input logic [7:0] wd, input bit doClr,
                      input bit doRd, input int n, input int k, input string req);
    int base;
    @(posedge clk);
    #1;
    wrStrobe = doWr;
    wrData   = wd;
    clear    = doClr;
    rdEn     = doRd;
    rdAlias  = {n[ADDR_W-1:0], k[2:0]};
    if (doRd) begin
      expQ.push_back(expectRead(n, k));
      reqQ.push_back(req);
    end
    base = doClr ? 0 : wp;
    if (doWr) begin
      model[base] = wd;
      wp = (base + 1) % NBYTES;
    end else if (doClr) begin
      wp = 0;
    end
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) step(0, 8'h00, 0, 0, 0, 0, "");
  endtask

  task automatic rd(input int n, input int k, input string req);
    step(0, 8'h00, 0, 1, n, k, req);
  endtask

  task automatic wr(input logic [7:0] d);
    step(1, d, 0, 0, 0, 0, "");
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (rdValid) begin
        if (expQ.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R4: actual rdValid 1 expected 0 (no read pending)");
        end else begin
          lastExp = expQ.pop_front();
          checkEq(rdData, lastExp, reqQ.pop_front());
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkEq(rdData, 8'h00, "R1 rdData in reset");
    checkEq({7'd0, rdValid}, 8'h00, "R1 rdValid in reset");
    @(posedge clk); #1 rstN = 1'b1;
    @(negedge clk);
    checkEq(rdData, 8'h00, "R1 rdData after reset");
    checkEq({7'd0, rdValid}, 8'h00, "R1 rdValid after reset");

    // Fill every byte with a distinct pattern.
    for (int i = 0; i < NBYTES; i++) wr(8'((i * 37 + 11) ^ (i << 3)));

    // R5: offset 0 is the byte itself, even and odd addresses.
    rd(0, 0, "R5 offset0 addr0");
    rd(5, 0, "R5 offset0 addr5");
    rd(22, 0, "R5 offset0 addr22");
    // R6: every offset at an even address, back to back.
    for (int k = 1; k < 8; k++) rd(10, k, "R6 even addr offset");
    // R7: every offset at an odd address.
    for (int k = 0; k < 8; k++) rd(33, k, "R7 odd addr offset");
    // R8: last address wraps to byte 0.
    for (int k = 0; k < 8; k++) rd(NBYTES - 1, k, "R8 last addr wrap");
    idle(2);

    // R10: output holds while no read is issued.
    idle(3);
    @(negedge clk);
    checkEq(rdData, lastExp, "R10 hold while idle");
    checkEq({7'd0, rdValid}, 8'h00, "R4 valid low while idle");

    // R3: clear together with a write stores at address 0, next at 1.
    step(1, 8'hC3, 1, 0, 0, 0, "");
    wr(8'h5A);
    rd(0, 0, "R3 clear+write lands at 0");
    rd(1, 0, "R3 next write lands at 1");
    rd(0, 4, "R3 pair across 0/1");
    // R3: clear alone returns pointer to 0.
    wr(8'h77);
    step(0, 8'h00, 1, 0, 0, 0, "");
    wr(8'h99);
    rd(0, 0, "R3 clear alone resets pointer");
    rd(2, 0, "R3 byte 2 kept");

    // R2: write a full pass so the pointer wraps and overwrites byte 0.
    for (int i = 1; i < NBYTES; i++) wr(8'(i ^ 8'hA5));
    wr(8'h3C);
    rd(0, 0, "R2 wrap overwrites byte 0");
    rd(1, 0, "R2 byte 1 from pass");
    rd(NBYTES - 1, 2, "R2 last byte after pass");

    // R9: read of the byte being written returns its old value, then the new one.
    step(1, 8'hE1, 0, 1, wp, 0, "R9 same cycle same byte old");
    rd(1, 0, "R9 next cycle sees new byte");
    // Read one below the write pointer, so the new byte is the second of the pair.
    step(1, 8'h0F, 0, 1, wp - 1, 3, "R9 same cycle second byte old");
    rd(1, 3, "R9 second byte new after write");
    // Odd write address as the first byte of the pair.
    step(1, 8'hB4, 0, 1, wp, 5, "R9 odd write same cycle");
    rd(3, 5, "R9 odd write visible");
    // Write and read together at unrelated addresses.
    step(1, 8'h12, 0, 1, 40, 6, "R9 unrelated read during write");
    idle(4);

    if (expQ.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL R4: actual %0d reads unanswered expected 0", expQ.size());
    end
    finishRun();
  end
endmodule